// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one host request into the full series of bus cycles that a raw 8-bit NAND flash device needs. The supported operations are device reset, identifier read, main-area page read and program, spare-area read and program, and block erase. The host gives a zone, block and page address plus a count. The sequencer then drives command-latch and address-latch cycles with write strobes, streams data bytes through a valid/ready handshake in each direction, and polls device status after program and erase. It steps through consecutive pages without host involvement.

Each bus cycle takes one clock. `nand_we` or `nand_re` pulses for that clock, and `nand_cle` or `nand_ale` marks a write as a command or an address byte. The device geometry, page and spare sizes, the settle delay after a confirm command and the status-poll limit are static configuration inputs. Every accepted request ends with a one-clock response that carries a result code and the number of pages or spare areas completed. Result codes are 0 for OK, 1 for device error and 2 for timeout.

Top module: `nand_seq`

## Requirements
- R1: A reset request (op 0) produces exactly one command write of 0xFF and no other strobe, then responds OK with 0 pages.
- R2: An identifier request (op 1) writes command 0x90, then one address byte 0x00, then makes four read strobes. The bytes read appear as `id_maker` (1st), `id_device` (2nd), `id_ext[7:0]` (3rd) and `id_ext[15:8]` (4th).
- R3: A page read (op 2) writes command 0x00, address 0x00, the row-address bytes least significant first, and command 0x30. It then reads `cfg_page_size` bytes and delivers them in order on `rd_data`. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.
- R4: Every page read, page program, spare read, spare program and erase sends four row-address bytes when `cfg_total_blocks` is 1024 or more, and three otherwise.
- R5: A page program (op 3) writes 0x00, then 0x80, then the 0x00 column byte and the row bytes. It then makes `cfg_page_size` write strobes that carry the accepted `wr_data` bytes in order, then writes command 0x10, then polls status.
- R6: Spare read (op 4) and spare program (op 5) follow R3 and R5, except that the first command is 0x50 and the transfer length is `cfg_spare_size`.
- R7: An erase (op 6) writes 0x60, then the row bytes with no column byte, then 0xD0, then polls status.
- R8: Each status poll writes command 0x70 and reads one byte. When bit 0 is set, the operation ends with code 1 even if bit 6 is also set. When only bit 6 is set, the page counts as done. When neither bit is set, polling repeats.
- R9: The row address is page + (block + zone × `cfg_blks_per_zone`) × `cfg_pages_per_blk`. After each unit the page advances. When the page reaches `cfg_pages_per_blk` it wraps to 0 and the block advances. When the block reaches `cfg_blks_per_zone` it wraps to 0 and the zone advances.
- R10: When the zone reaches `cfg_zone_limit`, the loop stops and responds OK with fewer pages than requested. A count of 0 responds OK with 0 pages and no bus strobe.
- R11: When `cfg_timeout` consecutive status reads all show busy, the operation ends with code 2.
- R12: `req_ready` is high only while idle. A `req_valid` seen while an operation runs raises `req_refused` for one clock and does not change the running operation.
- R13: After any confirm command (0x30, 0x10, 0xD0), the next strobe (a data read or the status command) comes exactly `cfg_wait` + 2 clocks after the confirm strobe.
- R14: `nand_cle` and `nand_ale` are only high together with `nand_we`, never both at once, and `nand_we` and `nand_re` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0 reset … 6 erase) |
| req_zone | input | ZONE_W | Start zone |
| req_block | input | BLK_W | Start block within zone |
| req_page | input | PAGE_W | Start page within block |
| req_count | input | CNT_W | Number of pages or spare areas |
| req_ready | output | 1 | Idle, request will be taken |
| req_refused | output | 1 | Pulse: request arrived while busy |
| rsp_valid | output | 1 | Pulse: operation finished |
| rsp_code | output | 2 | 0 OK, 1 device error, 2 timeout |
| rsp_pages | output | CNT_W | Units completed |
| id_maker | output | 8 | First identifier byte |
| id_device | output | 8 | Second identifier byte |
| id_ext | output | 16 | Fourth and third identifier bytes |
| cfg_pages_per_blk | input | PAGE_W+1 | Pages per block |
| cfg_blks_per_zone | input | BLK_W+1 | Blocks per zone |
| cfg_zone_limit | input | ZONE_W+1 | Number of zones |
| cfg_total_blocks | input | BLK_W+ZONE_W+1 | Total block count of the device |
| cfg_page_size | input | LEN_W | Main-area bytes per page |
| cfg_spare_size | input | LEN_W | Spare-area bytes per page |
| cfg_wait | input | WAIT_W | Settle clocks after a confirm command |
| cfg_timeout | input | TMO_W | Busy status reads allowed |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data valid |
| wr_ready | output | 1 | Program data accepted this clock |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | Host takes read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we | output | 1 | Write strobe |
| nand_re | output | 1 | Read strobe |
| nand_dout | output | 8 | Byte driven to the device |
| nand_din | input | 8 | Byte returned by the device |

## Verification
A wrong state transition shows up at once on the bus: a missing, extra or reordered command or address byte appears in the strobe trace of that same operation. A corrupt address counter shows as a wrong row byte on the next page of a multi-page request, or as an early or late stop that `rsp_pages` reports in the response. A mistake in the status decoder or the timeout counter changes `rsp_code`, or changes the number of 0x70 polls before the response. A mistake in the settle counter moves the first data or status strobe away from its fixed distance after the confirm command.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int PAGE_W = 6,
  parameter int BLK_W  = 10,
  parameter int ZONE_W = 2,
  parameter int CNT_W  = 8,
  parameter int LEN_W  = 12,
  parameter int WAIT_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [2:0]                  req_op,
  input  logic [ZONE_W-1:0]           req_zone,
  input  logic [BLK_W-1:0]            req_block,
  input  logic [PAGE_W-1:0]           req_page,
  input  logic [CNT_W-1:0]            req_count,
  output logic                        req_ready,
  output logic                        req_refused,
  output logic                        rsp_valid,
  output logic [1:0]                  rsp_code,
  output logic [CNT_W-1:0]            rsp_pages,
  output logic [7:0]                  id_maker,
  output logic [7:0]                  id_device,
  output logic [15:0]                 id_ext,
  input  logic [PAGE_W:0]             cfg_pages_per_blk,
  input  logic [BLK_W:0]              cfg_blks_per_zone,
  input  logic [ZONE_W:0]             cfg_zone_limit,
  input  logic [BLK_W+ZONE_W:0]       cfg_total_blocks,
  input  logic [LEN_W-1:0]            cfg_page_size,
  input  logic [LEN_W-1:0]            cfg_spare_size,
  input  logic [WAIT_W-1:0]           cfg_wait,
  input  logic [TMO_W-1:0]            cfg_timeout,
  input  logic [7:0]                  wr_data,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  output logic [7:0]                  rd_data,
  output logic                        rd_valid,
  input  logic                        rd_ready,
  output logic                        nand_cle,
  output logic                        nand_ale,
  output logic                        nand_we,
  output logic                        nand_re,
  output logic [7:0]                  nand_dout,
  input  logic [7:0]                  nand_din
);
  localparam int PW = PAGE_W + 1;
  localparam int BW = BLK_W + 1;
  localparam int ZW = ZONE_W + 1;
  localparam int FOUR_ROW_MIN = 1024;

  localparam logic [2:0] OP_RST = 3'd0, OP_RID = 3'd1, OP_PRD = 3'd2, OP_PPG = 3'd3,
                         OP_SRD = 3'd4, OP_SPG = 3'd5, OP_ERA = 3'd6;
  localparam logic [1:0] C_OK = 2'd0, C_ERR = 2'd1, C_TMO = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOP, S_CMD1, S_CMD2, S_COL, S_ROW, S_WDATA, S_CMD3,
    S_WAITC, S_RDATA, S_IDRD, S_SCMD, S_SRD, S_NEXT, S_FIN
  } st_t;

  st_t               st;
  logic [2:0]        op;
  logic [ZW-1:0]     zn;
  logic [BW-1:0]     blk;
  logic [PW-1:0]     pg;
  logic [CNT_W-1:0]  rem, dn;
  logic              addr_ok;
  logic [1:0]        ridx;
  logic [LEN_W-1:0]  xcnt;
  logic [WAIT_W-1:0] wcnt;
  logic [TMO_W-1:0]  tcnt;
  logic [1:0]        code;

  logic [31:0]      row;
  logic [1:0]       last_ridx;
  logic             is_rd, is_wr, is_spare;
  logic [LEN_W-1:0] xlen;
  logic [7:0]       cmd_first, cmd_conf;

  assign row = 32'(pg) + (32'(blk) + 32'(zn) * 32'(cfg_blks_per_zone)) * 32'(cfg_pages_per_blk);
  assign last_ridx = (32'(cfg_total_blocks) >= 32'(FOUR_ROW_MIN)) ? 2'd3 : 2'd2;
  assign is_rd    = (op == OP_PRD) || (op == OP_SRD);
  assign is_wr    = (op == OP_PPG) || (op == OP_SPG);
  assign is_spare = (op == OP_SRD) || (op == OP_SPG);
  assign xlen     = is_spare ? cfg_spare_size : cfg_page_size;
  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_WDATA);

  always_comb begin
    case (op)
      OP_RST:         cmd_first = 8'hFF;
      OP_RID:         cmd_first = 8'h90;
      OP_SRD, OP_SPG: cmd_first = 8'h50;
      OP_ERA:         cmd_first = 8'h60;
      default:        cmd_first = 8'h00;
    endcase
    cmd_conf = is_rd ? 8'h30 : (is_wr ? 8'h10 : 8'hD0);
  end

  always_comb begin
    nand_cle = 1'b0; nand_ale = 1'b0; nand_we = 1'b0; nand_re = 1'b0; nand_dout = 8'h00;
    case (st)
      S_CMD1:  begin nand_we = 1'b1; nand_cle = 1'b1; nand_dout = cmd_first; end
      S_CMD2:  begin nand_we = 1'b1; nand_cle = 1'b1; nand_dout = 8'h80; end
      S_COL:   begin nand_we = 1'b1; nand_ale = 1'b1; end
      S_ROW:   begin nand_we = 1'b1; nand_ale = 1'b1; nand_dout = row[ridx*8 +: 8]; end
      S_WDATA: begin nand_we = wr_valid; nand_dout = wr_data; end
      S_CMD3:  begin nand_we = 1'b1; nand_cle = 1'b1; nand_dout = cmd_conf; end
      S_SCMD:  begin nand_we = 1'b1; nand_cle = 1'b1; nand_dout = 8'h70; end
      S_RDATA: nand_re = !rd_valid || rd_ready;
      S_IDRD, S_SRD: nand_re = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_RST; zn <= '0; blk <= '0; pg <= '0;
      rem <= '0; dn <= '0; addr_ok <= 1'b1; ridx <= '0; xcnt <= '0;
      wcnt <= '0; tcnt <= '0; code <= C_OK;
      req_refused <= 1'b0; rsp_valid <= 1'b0; rsp_code <= C_OK; rsp_pages <= '0;
      id_maker <= '0; id_device <= '0; id_ext <= '0;
      rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      rsp_valid   <= 1'b0;
      req_refused <= req_valid && (st != S_IDLE);
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op <= req_op; zn <= ZW'(req_zone); blk <= BW'(req_block); pg <= PW'(req_page);
          rem <= req_count; dn <= '0; addr_ok <= 1'b1; code <= C_OK;
          if (req_op == OP_RST || req_op == OP_RID) st <= S_CMD1;
          else if (req_op == 3'd7) st <= S_FIN;
          else st <= S_LOOP;
        end
        S_LOOP: st <= (rem == '0 || !addr_ok) ? S_FIN : S_CMD1;
        S_CMD1: begin
          ridx <= '0;
          case (op)
            OP_RST:         st <= S_FIN;
            OP_ERA:         st <= S_ROW;
            OP_PPG, OP_SPG: st <= S_CMD2;
            default:        st <= S_COL;
          endcase
        end
        S_CMD2: st <= S_COL;
        S_COL: begin
          xcnt <= '0; ridx <= '0;
          st <= (op == OP_RID) ? S_IDRD : S_ROW;
        end
        S_ROW: begin
          xcnt <= '0;
          if (ridx == last_ridx) st <= is_wr ? S_WDATA : S_CMD3;
          else ridx <= ridx + 2'd1;
        end
        S_WDATA: if (wr_valid) begin
          if (xcnt == xlen - LEN_W'(1)) st <= S_CMD3;
          else xcnt <= xcnt + LEN_W'(1);
        end
        S_CMD3: begin
          wcnt <= '0; tcnt <= '0; xcnt <= '0; st <= S_WAITC;
        end
        S_WAITC: begin
          if (wcnt == cfg_wait) st <= is_rd ? S_RDATA : S_SCMD;
          else wcnt <= wcnt + WAIT_W'(1);
        end
        S_RDATA: if (nand_re) begin
          rd_data <= nand_din; rd_valid <= 1'b1;
          if (xcnt == xlen - LEN_W'(1)) st <= S_NEXT;
          else xcnt <= xcnt + LEN_W'(1);
        end
        S_IDRD: begin
          case (xcnt[1:0])
            2'd0: id_maker <= nand_din;
            2'd1: id_device <= nand_din;
            2'd2: id_ext[7:0] <= nand_din;
            default: id_ext[15:8] <= nand_din;
          endcase
          if (xcnt[1:0] == 2'd3) st <= S_FIN;
          else xcnt <= xcnt + LEN_W'(1);
        end
        S_SCMD: st <= S_SRD;
        S_SRD: begin
          if (nand_din[0]) begin code <= C_ERR; st <= S_FIN; end
          else if (nand_din[6]) st <= S_NEXT;
          else if (tcnt + TMO_W'(1) >= cfg_timeout) begin code <= C_TMO; st <= S_FIN; end
          else begin tcnt <= tcnt + TMO_W'(1); st <= S_SCMD; end
        end
        S_NEXT: begin
          rem <= rem - CNT_W'(1);
          dn  <= dn + CNT_W'(1);
          if (pg + PW'(1) == cfg_pages_per_blk) begin
            pg <= '0;
            if (blk + BW'(1) == cfg_blks_per_zone) begin
              blk <= '0;
              zn  <= zn + ZW'(1);
              addr_ok <= (zn + ZW'(1)) < cfg_zone_limit;
            end else blk <= blk + BW'(1);
          end else pg <= pg + PW'(1);
          st <= S_LOOP;
        end
        S_FIN: begin
          rsp_valid <= 1'b1; rsp_code <= code; rsp_pages <= dn; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R14
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_we && nand_re) && !(nand_cle && nand_ale) && !((nand_cle || nand_ale) && !nand_we));

  // R8
  status_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SRD && nand_din[0]) |=> ##1 (rsp_valid && rsp_code == C_ERR));

  // R11
  tmo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == C_TMO) |-> ($past(nand_re, 2) && !$past(nand_din[6], 2) && !$past(nand_din[0], 2)));

  // R13
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD3) |=> (!nand_we && !nand_re));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/test_nand_seq.sv
module test_nand_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_zone = '0;
  logic [9:0] req_block = '0;
  logic [5:0] req_page = '0;
  logic [7:0] req_count = '0;
  logic req_ready, req_refused, rsp_valid;
  logic [1:0] rsp_code;
  logic [7:0] rsp_pages, id_maker, id_device;
  logic [15:0] id_ext;
  logic [6:0]  cfg_ppb = 7'd4;
  logic [10:0] cfg_bpz = 11'd2;
  logic [2:0]  cfg_zlim = 3'd2;
  logic [12:0] cfg_total = 13'd16;
  logic [11:0] cfg_psz = 12'd4, cfg_ssz = 12'd2;
  logic [7:0]  cfg_wait = 8'd2;
  logic [15:0] cfg_tmo = 16'd5;
  logic [7:0] wr_data;
  logic wr_valid = 1'b1, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 1'b1;
  logic nand_cle, nand_ale, nand_we, nand_re;
  logic [7:0] nand_dout, nand_din;

  nand_seq i_nand_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_zone(req_zone),
    .req_block(req_block), .req_page(req_page), .req_count(req_count), .req_ready(req_ready),
    .req_refused(req_refused), .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pages(rsp_pages),
    .id_maker(id_maker), .id_device(id_device), .id_ext(id_ext),
    .cfg_pages_per_blk(cfg_ppb), .cfg_blks_per_zone(cfg_bpz), .cfg_zone_limit(cfg_zlim),
    .cfg_total_blocks(cfg_total), .cfg_page_size(cfg_psz), .cfg_spare_size(cfg_ssz),
    .cfg_wait(cfg_wait), .cfg_timeout(cfg_tmo), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we), .nand_re(nand_re),
    .nand_dout(nand_dout), .nand_din(nand_din));

  int checks = 0, errors = 0, cyc = 0, viol = 0;
  bit finished = 1'b0;

  // device model
  int mode = 0, idcnt = 0, busy_left = 0;
  logic [7:0] stat_final = 8'h40, dctr = 8'h10, wctr = 8'hA0;
  logic [7:0] id_bytes [4] = '{8'hEC, 8'hD3, 8'h51, 8'h95};
  assign nand_din = (mode == 1) ? ((busy_left > 0) ? 8'h00 : stat_final) :
                    (mode == 2) ? id_bytes[idcnt[1:0]] : dctr;
  assign wr_data = wctr;

  // logs
  int lt [512]; int lc [512]; int ln = 0;
  int et [512]; int en = 0;
  logic [7:0] rbuf [64]; int rn = 0;
  bit f_cmd, f_re, f_wr, stall = 1'b0;
  logic [7:0] f_byte;

  always @(negedge clk) begin
    cyc++;
    if ((nand_we && nand_re) || (nand_cle && nand_ale) || ((nand_cle || nand_ale) && !nand_we)) viol++;
    f_cmd = nand_we && nand_cle; f_byte = nand_dout; f_re = nand_re;
    f_wr = wr_valid && wr_ready;
    if (nand_we && ln < 512) begin
      lt[ln] = (nand_cle ? 256 : nand_ale ? 512 : 768) + int'(nand_dout); lc[ln] = cyc; ln++;
    end else if (nand_re && ln < 512) begin
      lt[ln] = 0; lc[ln] = cyc; ln++;
    end
    if (rd_valid && rd_ready && rn < 64) begin rbuf[rn] = rd_data; rn++; end
  end

  always @(posedge clk) begin
    #2;
    if (f_cmd) begin
      mode = (f_byte == 8'h70) ? 1 : (f_byte == 8'h90) ? 2 : 0;
      idcnt = 0;
    end
    if (f_re) begin
      if (mode == 1) begin if (busy_left > 0) busy_left--; end
      else if (mode == 2) idcnt++;
      else dctr = dctr + 8'd1;
    end
    if (f_wr) wctr = wctr + 8'd1;
    f_cmd = 1'b0; f_re = 1'b0; f_wr = 1'b0;
    rd_ready = stall ? ~rd_ready : 1'b1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ec(int b); et[en] = 256 + b; en++; endtask
  task automatic ea(int b); et[en] = 512 + b; en++; endtask
  task automatic er(int n); for (int i = 0; i < n; i++) begin et[en] = 0; en++; end endtask
  task automatic ew(int n, inout logic [7:0] w);
    for (int i = 0; i < n; i++) begin et[en] = 768 + int'(w); en++; w = w + 8'd1; end
  endtask
  task automatic erow(int r, int four);
    ea(r & 255); ea((r >> 8) & 255); ea((r >> 16) & 255);
    if (four != 0) ea((r >> 24) & 255);
  endtask

  task automatic cmp_trace(string tag);
    int bad = -1;
    chk({tag, " trace length"}, ln, en);
    for (int i = 0; i < en && i < ln; i++) if (lt[i] != et[i] && bad < 0) bad = i;
    if (bad >= 0) chk({tag, " trace entry"}, lt[bad], et[bad]);
    else chk({tag, " trace entries"}, 0, 0);
  endtask

  // distance from entry equal to value v to the following entry
  function automatic int gap_after(int v);
    for (int i = 0; i + 1 < ln; i++) if (lt[i] == v) return lc[i+1] - lc[i];
    return -1;
  endfunction

  logic [1:0] got_code; int got_pages;

  task automatic start(int op, int z, int b, int p, int n);
    @(negedge clk); #1;
    ln = 0; en = 0; rn = 0;
    req_op = 3'(op); req_zone = 2'(z); req_block = 10'(b); req_page = 6'(p); req_count = 8'(n);
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(string tag);
    int k = 0;
    while (!rsp_valid && k < 4000) begin @(negedge clk); k++; end
    chk({tag, " response seen"}, int'(rsp_valid), 1);
    got_code = rsp_code; got_pages = int'(rsp_pages);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R12 idle ready after reset", int'(req_ready), 1);
    chk("R12 no response after reset", int'(rsp_valid), 0);
    chk("R3 no read data after reset", int'(rd_valid), 0);
    chk("R14 no strobe after reset", int'(nand_we | nand_re), 0);
  endtask

  task automatic t_r1();
    start(0, 0, 0, 0, 0); wait_rsp("R1");
    ec(8'hFF); cmp_trace("R1 reset");
    chk("R1 code", got_code, 0); chk("R1 pages", got_pages, 0);
  endtask

  task automatic t_r2();
    start(1, 0, 0, 0, 0); wait_rsp("R2");
    ec(8'h90); ea(8'h00); er(4); cmp_trace("R2 id");
    chk("R2 maker", id_maker, 8'hEC); chk("R2 device", id_device, 8'hD3);
    chk("R2 ext", id_ext, 16'h9551);
  endtask

  task automatic t_r3();
    logic [7:0] base = dctr;
    start(2, 0, 1, 2, 1); wait_rsp("R3");
    ec(8'h00); ea(8'h00); erow(6, 0); ec(8'h30); er(4); cmp_trace("R3 page read");
    chk("R3 bytes delivered", rn, 4);
    for (int i = 0; i < 4 && i < rn; i++) chk("R3 read byte", rbuf[i], 8'(base + 8'(i)));
    chk("R13 gap after read confirm", gap_after(256 + 8'h30), int'(cfg_wait) + 2);
    chk("R3 code", got_code, 0); chk("R3 pages", got_pages, 1);
  endtask

  task automatic t_r9();
    logic [7:0] base = dctr;
    stall = 1'b1;
    start(2, 0, 1, 3, 2); wait_rsp("R9");
    repeat (4) @(negedge clk);
    stall = 1'b0;
    ec(8'h00); ea(8'h00); erow(7, 0); ec(8'h30); er(4);
    ec(8'h00); ea(8'h00); erow(8, 0); ec(8'h30); er(4);
    cmp_trace("R9 block and zone rollover");
    chk("R3 stalled bytes delivered", rn, 8);
    for (int i = 0; i < 8 && i < rn; i++) chk("R3 stalled byte order", rbuf[i], 8'(base + 8'(i)));
    chk("R9 pages", got_pages, 2);
  endtask

  task automatic t_r10();
    start(2, 1, 1, 3, 3); wait_rsp("R10");
    ec(8'h00); ea(8'h00); erow(15, 0); ec(8'h30); er(4); cmp_trace("R10 end stop");
    chk("R10 code", got_code, 0); chk("R10 early pages", got_pages, 1);
    start(2, 0, 0, 0, 0); wait_rsp("R10 zero");
    cmp_trace("R10 zero count");
    chk("R10 zero pages", got_pages, 0); chk("R10 zero code", got_code, 0);
  endtask

  task automatic t_r4();
    cfg_total = 13'd2048;
    start(2, 0, 0, 1, 1); wait_rsp("R4");
    ec(8'h00); ea(8'h00); erow(1, 1); ec(8'h30); er(4); cmp_trace("R4 four row bytes");
    cfg_total = 13'd16;
  endtask

  task automatic t_r5();
    logic [7:0] w = wctr;
    busy_left = 2; stat_final = 8'h40;
    start(3, 0, 0, 0, 1); wait_rsp("R5");
    ec(8'h00); ec(8'h80); ea(8'h00); erow(0, 0); ew(4, w); ec(8'h10);
    repeat (3) begin ec(8'h70); er(1); end
    cmp_trace("R5 page program");
    chk("R13 gap after program confirm", gap_after(256 + 8'h10), int'(cfg_wait) + 2);
    chk("R5 code", got_code, 0); chk("R5 pages", got_pages, 1);
  endtask

  task automatic t_r6();
    logic [7:0] base = dctr;
    logic [7:0] w;
    start(4, 0, 0, 1, 1); wait_rsp("R6 read");
    ec(8'h50); ea(8'h00); erow(1, 0); ec(8'h30); er(2); cmp_trace("R6 spare read");
    chk("R6 spare bytes", rn, 2);
    if (rn > 1) chk("R6 spare byte", rbuf[1], 8'(base + 8'd1));
    w = wctr; busy_left = 0; stat_final = 8'h40;
    start(5, 0, 0, 2, 1); wait_rsp("R6 prog");
    ec(8'h50); ec(8'h80); ea(8'h00); erow(2, 0); ew(2, w); ec(8'h10); ec(8'h70); er(1);
    cmp_trace("R6 spare program");
    chk("R6 prog pages", got_pages, 1);
  endtask

  task automatic t_r7();
    busy_left = 0; stat_final = 8'h40;
    start(6, 0, 1, 0, 1); wait_rsp("R7");
    ec(8'h60); erow(4, 0); ec(8'hD0); ec(8'h70); er(1); cmp_trace("R7 erase");
    chk("R13 gap after erase confirm", gap_after(256 + 8'hD0), int'(cfg_wait) + 2);
    chk("R7 code", got_code, 0);
  endtask

  task automatic t_r8();
    logic [7:0] w = wctr;
    busy_left = 1; stat_final = 8'h41;
    start(3, 0, 0, 0, 2); wait_rsp("R8");
    ec(8'h00); ec(8'h80); ea(8'h00); erow(0, 0); ew(4, w); ec(8'h10);
    ec(8'h70); er(1); ec(8'h70); er(1);
    cmp_trace("R8 error priority");
    chk("R8 error code", got_code, 1); chk("R8 pages", got_pages, 0);
    stat_final = 8'h40;
  endtask

  task automatic t_r11();
    busy_left = 100;
    start(6, 0, 0, 0, 1); wait_rsp("R11");
    ec(8'h60); erow(0, 0); ec(8'hD0);
    repeat (5) begin ec(8'h70); er(1); end
    cmp_trace("R11 timeout polls");
    chk("R11 timeout code", got_code, 2); chk("R11 pages", got_pages, 0);
    busy_left = 0;
  endtask

  task automatic t_r12();
    int seen = 0;
    busy_left = 3; stat_final = 8'h40;
    start(6, 0, 1, 0, 1);
    repeat (2) @(negedge clk);
    chk("R12 not ready while busy", int'(req_ready), 0);
    #1; req_op = 3'd0; req_valid = 1'b1;
    @(negedge clk); #1; req_valid = 1'b0;
    seen = int'(req_refused);
    @(negedge clk);
    chk("R12 refused pulse", seen, 1);
    chk("R12 refused one clock", int'(req_refused), 0);
    wait_rsp("R12");
    ec(8'h60); erow(4, 0); ec(8'hD0);
    repeat (4) begin ec(8'h70); er(1); end
    cmp_trace("R12 op unaffected");
    chk("R12 code", got_code, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_r1(); t_r2(); t_r3(); t_r9(); t_r10(); t_r4();
    t_r5(); t_r6(); t_r7(); t_r8(); t_r11(); t_r12();
    chk("R14 strobe rule violations", viol, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule